// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

A bus-mapped supervision timer for a large chip. A down-counter restarts from a programmed period. When it runs out the first time it raises an interrupt flag and starts again. If it runs out a second time while that flag is still pending, and the reset stage is armed, the block drives a system reset request. That request stays high until the block's own reset is applied. Software keeps the system alive by clearing the interrupt, which also restarts the period.

Register access uses a simple two-phase bus with select, enable, write, address, write data and read data. A write takes effect on the clock edge where select, enable and write are all high. Reads are combinational from the address. A lock register guards all other registers against stray writes. It opens only when it receives a magic key, and any other value written to it closes it again.

Top module: `wdg_timer`

## Requirements
- R1: After reset, the period and count registers read 0xFFFFFFFF. Control, raw status and masked status read 0. The lock register reads 0 (unlocked). Both output pins are low.
- R2: The address map is as follows. Period at 0x000 (read/write). Count at 0x004 (read-only). Control at 0x008, where bit 0 is run and bit 1 arms the reset stage. Interrupt clear at 0x00C (write-only; it reads 0). Raw status at 0x010, bit 0. Masked status at 0x014, bit 0. Lock at 0xC00. Any other address reads 0.
- R3: Writing 0x1ACCE551 to the lock register unlocks the block. Writing any other value locks it. The lock register reads 1 when locked and 0 when unlocked. Writes to the lock register are always accepted.
- R4: While locked, writes to the period, control and interrupt-clear registers have no effect.
- R5: While control bit 0 is set, the count decreases by one on every clock. While bit 0 is clear, the count holds its value.
- R6: On a clock where the block is running and the count is 0, the raw flag sets and the count restarts from the period.
- R7: A second expiry while the raw flag is set and control bit 1 is set raises the reset pin. The pin then stays high until the reset input is applied. With bit 1 clear, the reset pin never rises. After a service, the reset pin rises on the 2×(period+1)-th clock.
- R8: An accepted period write loads the count with the written value on the same edge. An accepted interrupt-clear write clears the raw flag and loads the count from the period on the same edge.
- R9: Masked status and the interrupt pin both equal the raw flag ANDed with control bit 0.
- R10: A period of 0 is legal. With the period at 0 and both control bits set, the raw flag sets on the first running clock and the reset pin rises on the second.
- R11: An accepted period or interrupt-clear write on the same clock as an expiry takes priority, and the expiry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| irq_o | output | 1 | Interrupt request (masked status) |
| wdog_rst_o | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach is a service write that lands on exactly the clock where the count is 0. Getting there means placing the second edge of a two-phase write on that one cycle. The bench counts edges from a known reload and starts the write two clocks early, so the access edge coincides with the expiry. A behavioural model in the bench tracks every register each clock and compares the pins and the addressed read data on every falling edge. Separate edge counts confirm when the reset pin rises after a service and with a zero period.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_PERIOD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'hC00;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

    // control fields: bit 1 arms reset, bit 0 runs the counter
    typedef struct packed {
        logic rst_arm;
        logic run;
    } ctrl_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PERIOD,
        TGT_CTRL,
        TGT_CLEAR,
        TGT_LOCK
    } wr_tgt_e;

    function automatic wr_tgt_e decode_wr(logic [ADDR_W-1:0] a);
        case (a)
            OFS_PERIOD: return TGT_PERIOD;
            OFS_CTRL:   return TGT_CTRL;
            OFS_CLEAR:  return TGT_CLEAR;
            OFS_LOCK:   return TGT_LOCK;
            default:    return TGT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DW = wdg_pkg::DATA_W,
    parameter int AW = wdg_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_i,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] period_q,
    output ctrl_t         ctrl_q,
    output logic          locked_q,
    output logic          period_wr,
    output logic          clear_wr
);
    logic    access;
    wr_tgt_e tgt;

    assign access = psel && penable && pwrite;
    assign tgt    = access ? decode_wr(paddr) : TGT_NONE;

    assign period_wr = !locked_q && (tgt == TGT_PERIOD);
    assign clear_wr  = !locked_q && (tgt == TGT_CLEAR);

    always_ff @(posedge clk) begin
        if (rst_i) begin
            locked_q <= 1'b0;
            period_q <= '1;
            ctrl_q   <= '0;
        end else begin
            if (tgt == TGT_LOCK) begin
                locked_q <= (pwdata != UNLOCK_KEY);
            end
            if (!locked_q) begin
                case (tgt)
                    TGT_PERIOD: period_q <= pwdata;
                    TGT_CTRL:   ctrl_q   <= ctrl_t'(pwdata[1:0]);
                    default:    ;
                endcase
            end
        end
    end

    // R4: a locked block keeps its configuration
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst_i)
        (locked_q && access) |=> ($stable(period_q) && $stable(ctrl_q)));

    // R3: the key opens the block
    a_r3_key_opens: assert property (@(posedge clk) disable iff (rst_i)
        (access && paddr == OFS_LOCK && pwdata == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int DW = wdg_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_i,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] period,
    input  logic          period_wr,
    input  logic          clear_wr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] count_q,
    output logic          raw_q,
    output logic          rst_q
);
    logic serviced;
    logic at_zero;
    logic expire;

    assign serviced = period_wr || clear_wr;
    assign at_zero  = (count_q == '0);
    assign expire   = ctrl.run && at_zero && !serviced;

    always_ff @(posedge clk) begin
        if (rst_i) begin
            count_q <= '1;
            raw_q   <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            if (period_wr) begin
                count_q <= wr_data;
            end else if (clear_wr) begin
                count_q <= period;
            end else if (ctrl.run) begin
                count_q <= at_zero ? period : count_q - 1'b1;
            end

            if (clear_wr) begin
                raw_q <= 1'b0;
            end else if (expire) begin
                raw_q <= 1'b1;
            end

            if (expire && raw_q && ctrl.rst_arm) begin
                rst_q <= 1'b1;
            end
        end
    end

    // R5: stopped counter holds
    a_r5_hold: assert property (@(posedge clk) disable iff (rst_i)
        (!ctrl.run && !serviced) |=> $stable(count_q));

    // R5: running counter steps down by one
    a_r5_step: assert property (@(posedge clk) disable iff (rst_i)
        (ctrl.run && !at_zero && !serviced) |=> (count_q == $past(count_q) - 1'b1));

    // R6: expiry leaves the raw flag set
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst_i)
        (ctrl.run && at_zero && !serviced) |=> raw_q);

    // R7: reset request is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst_i)
        rst_q |=> rst_q);

    // R7: reset request needs a pending flag and the arm bit
    a_r7_cause: assert property (@(posedge clk) disable iff (rst_i)
        $rose(rst_q) |-> ($past(raw_q) && $past(ctrl.rst_arm)));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_i,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq_o,
    output logic              wdog_rst_o
);
    logic [DATA_W-1:0] period_q;
    ctrl_t             ctrl_q;
    logic              locked_q;
    logic              period_wr;
    logic              clear_wr;
    logic [DATA_W-1:0] count_q;
    logic              raw_q;
    logic              masked;

    wdg_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_i     (rst_i),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .period_q  (period_q),
        .ctrl_q    (ctrl_q),
        .locked_q  (locked_q),
        .period_wr (period_wr),
        .clear_wr  (clear_wr)
    );

    wdg_core #(.DW(DATA_W)) u_core (
        .clk       (clk),
        .rst_i     (rst_i),
        .ctrl      (ctrl_q),
        .period    (period_q),
        .period_wr (period_wr),
        .clear_wr  (clear_wr),
        .wr_data   (pwdata),
        .count_q   (count_q),
        .raw_q     (raw_q),
        .rst_q     (wdog_rst_o)
    );

    assign masked = raw_q && ctrl_q.run;
    assign irq_o  = masked;

    always_comb begin
        prdata = '0;
        case (paddr)
            OFS_PERIOD: prdata = period_q;
            OFS_COUNT:  prdata = count_q;
            OFS_CTRL:   prdata[1:0] = ctrl_q;
            OFS_RAW:    prdata[0] = raw_q;
            OFS_MASKED: prdata[0] = masked;
            OFS_LOCK:   prdata[0] = locked_q;
            default:    prdata = '0;
        endcase
    end

    // R9: interrupt pin never outlives the run bit
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst_i)
        $fell(ctrl_q.run) |-> !irq_o);
endmodule

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;
    import wdg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o, wdog_rst_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    wdg_timer u_wdg_timer (
        .clk(clk), .rst_i(rst_i), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
    );

    // behavioural reference
    bit          m_valid = 0, m_locked, m_run, m_arm, m_raw, m_rst;
    logic [31:0] m_per, m_cnt;

    function automatic logic [31:0] mread(logic [11:0] a);
        case (a)
            12'h000: return m_per;
            12'h004: return m_cnt;
            12'h008: return {30'd0, m_arm, m_run};
            12'h010: return {31'd0, m_raw};
            12'h014: return {31'd0, m_raw & m_run};
            12'hC00: return {31'd0, m_locked};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst_i) begin
            m_valid = 1; m_locked = 0; m_run = 0; m_arm = 0; m_raw = 0; m_rst = 0;
            m_per = 32'hFFFFFFFF; m_cnt = 32'hFFFFFFFF;
        end else begin
            bit wr, lk, run, arm, raw, svc;
            logic [31:0] per, cnt;
            wr = psel && penable && pwrite;
            lk = m_locked; run = m_run; arm = m_arm; raw = m_raw; per = m_per; cnt = m_cnt;
            svc = 0;
            if (wr && paddr == 12'hC00) m_locked = (pwdata != 32'h1ACCE551);
            if (wr && !lk) begin
                if (paddr == 12'h000) begin m_per = pwdata; m_cnt = pwdata; svc = 1; end
                if (paddr == 12'h008) begin m_run = pwdata[0]; m_arm = pwdata[1]; end
                if (paddr == 12'h00C) begin m_raw = 0; m_cnt = per; svc = 1; end
            end
            if (!svc && run) begin
                if (cnt == 0) begin
                    if (raw && arm) m_rst = 1;
                    m_raw = 1;
                    m_cnt = per;
                end else m_cnt = cnt - 1;
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_i && m_valid) begin
            chk({31'd0, irq_o}, {31'd0, m_raw & m_run}, "R9 interrupt pin vs model");
            chk({31'd0, wdog_rst_o}, {31'd0, m_rst}, "R7 reset pin vs model");
            chk(prdata, mread(paddr), "R2 read data vs model");
        end
    end

    // all tasks start just after a rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(posedge clk); #1 penable = 1;
        @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); chk(prdata, exp, tag);
        @(posedge clk); #1 psel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_i = 1; idle(2); rst_i = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        idle(3); rst_i = 0;
        // R1 reset state
        rd(12'h000, 32'hFFFFFFFF, "R1 period after reset");
        rd(12'h004, 32'hFFFFFFFF, "R1 count after reset");
        rd(12'h008, 0, "R1 control after reset");
        rd(12'h014, 0, "R1 masked after reset");
        rd(12'hC00, 0, "R1 lock after reset");
        rd(12'h100, 0, "R2 unmapped reads zero");
        chk({30'd0, irq_o, wdog_rst_o}, 0, "R1 pins low after reset");
        // R8 period write loads count, R5 stopped count holds
        wr(12'h000, 32'd5);
        rd(12'h004, 5, "R8 count loaded by period write");
        idle(4);
        rd(12'h004, 5, "R5 stopped count holds");
        // R3/R4 lock
        wr(12'hC00, 32'd1);
        rd(12'hC00, 1, "R3 lock reads 1");
        wr(12'h000, 32'd99);
        wr(12'h008, 32'd3);
        rd(12'h000, 5, "R4 period write ignored while locked");
        rd(12'h008, 0, "R4 control write ignored while locked");
        wr(12'hC00, 32'h1ACCE551);
        rd(12'hC00, 0, "R3 key unlocks");
        // R6/R9 first expiry with run only
        wr(12'h008, 32'd1);
        idle(8);
        rd(12'h010, 1, "R6 raw flag after expiry");
        chk({31'd0, irq_o}, 1, "R9 interrupt pin with run set");
        wr(12'h008, 32'd0);
        rd(12'h014, 0, "R9 masked clears with run off");
        rd(12'h010, 1, "R9 raw stays set with run off");
        wr(12'h00C, 32'd0);
        rd(12'h010, 0, "R8 clear write drops raw flag");
        // R7 arm, service, then let it fire
        wr(12'h008, 32'd3);
        for (int i = 0; i < 8; i++) begin
            wr(12'h00C, 32'd0);
            idle(2);
        end
        chk({31'd0, wdog_rst_o}, 0, "R8 serviced timer never resets");
        wr(12'h00C, 32'd0);
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!wdog_rst_o && n < 100);
        chk(n, 12, "R7 reset edge after service, period 5");
        idle(1);
        wr(12'h00C, 32'd0);
        wr(12'h008, 32'd0);
        idle(10);
        chk({31'd0, wdog_rst_o}, 1, "R7 reset pin sticky");
        do_reset();
        chk({31'd0, wdog_rst_o}, 0, "R7 reset input clears pin");
        // R7 no reset with arm bit clear
        wr(12'h000, 32'd2);
        wr(12'h008, 32'd1);
        idle(30);
        chk({31'd0, wdog_rst_o}, 0, "R7 no reset without arm bit");
        rd(12'h010, 1, "R7 raw set while unarmed");
        // R11 clear on expiry edge wins
        wr(12'h000, 32'd3);
        wr(12'h00C, 32'd0);
        idle(2);
        wr(12'h00C, 32'd0);
        rd(12'h010, 0, "R11 clear beats same-cycle expiry");
        // R10 period zero
        do_reset();
        wr(12'h000, 32'd0);
        wr(12'h008, 32'd3);
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!wdog_rst_o && n < 100);
        chk(n, 2, "R10 zero period resets on second clock");
        idle(2);
        finish_run();
    end
endmodule